// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two Synchronous SRAM

This block is a synthesizable behavioural model of a pipelined synchronous SRAM whose data pins carry one half-word on each edge of the clock. Each array location is a 36-bit word seen on the pins as two 18-bit beats. Each half-word is split into two 9-bit bytes, and each byte has its own active-low write strobe. A command is taken on each rising edge of `k_clk`, which stands for the positive input clock K. The falling edge of `k_clk` stands for the rising edge of the complementary clock K#. Reads return data two K rises after the command. Write data follows the command by one cycle.

Writes are posted. The most recent complete write waits in a holding register and goes into the array only when the data of a later write has arrived. A read sees its address through that holding register. The strobed bytes of the held write take precedence over the array contents, so a read right after a write returns the newest data. The output enable and a first-beat marker are brought out so that bus turnaround can be observed cycle by cycle.

The address width is a parameter. The default is kept small so that the array elaborates quickly. Setting `ADDR_W` to 21 gives the full two-million-word organisation.

Top module: `ddr_burst_sram`

## Requirements
- R1: A read is issued when `ld_n` is 0 and `rw` is 1 at a rising edge of `k_clk`. `addr` is captured at that edge.
- R2: A write is issued when `ld_n` is 0 and `rw` is 0 at a rising edge of `k_clk`. A write command must not be issued at either of the two K rises that follow a read command.
- R3: For a read issued at K rise n, `q_out` carries word bits [17:0] from K rise n+2 until the next falling edge of `k_clk`. It then carries bits [35:18] until K rise n+3.
- R4: For a write issued at K rise n, `d_in` is sampled at K rise n+1 as word bits [17:0]. It is sampled again at the following falling edge as bits [35:18].
- R5: `bw_n` is sampled with each data beat and is active low. `bw_n[0]` enables beat bits [8:0] and `bw_n[1]` enables beat bits [17:9]. A byte whose strobe is 1 keeps its old content.
- R6: The newest complete write is held outside the array until a later write's data is complete. It stays readable at its address throughout.
- R7: A read whose address matches the held write returns the held write's strobed bytes. Its other bytes come from the array. This includes a read issued one cycle after the write.
- R8: `q_oe` is 1 exactly during the two beat windows of a read, and `q_out` is 0 whenever `q_oe` is 0.
- R9: `q_first` is 1 only during the first-beat window of a read.
- R10: While `ld_n` is 1 and no write beat is due, `addr`, `rw`, `d_in` and `bw_n` have no effect on the stored data.
- R11: After synchronous reset (`rst_n` low at a K rise), `q_oe`, `q_first` and `q_out` are 0, and reads that were in flight produce no output.
- R12: Reads issued on consecutive K rises stream out back to back with no gap on `q_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| k_clk | input | 1 | Clock. Rising edge is K, falling edge is K# |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_n | input | 1 | Active-low command select |
| rw | input | 1 | 1 selects read, 0 selects write |
| addr | input | ADDR_W | Word address |
| d_in | input | 18 | Write data beat |
| bw_n | input | 2 | Active-low byte strobes for the current beat |
| q_out | output | 18 | Read data beat, 0 when not enabled |
| q_oe | output | 1 | Read data driven on the bus |
| q_first | output | 1 | First beat of a burst on the bus |

## Verification
A read can meet a write to the same address while that write's data is still in the holding register. In that case the bypass merge and the array lookup act on the same read. In the same cycle, an array commit of the previously held write may also take place. The bench provokes this by issuing a write and then a read of the same address on the next K rise, using full and partial strobe masks. It also issues a write to a second address followed by a read of the first, and uses random traffic over a narrow address range to make collisions common. Every read beat is compared with a reference memory that takes each write in command order.

// File: rtl/ddrb_pkg.sv
`timescale 1ns/1ps
// Shared types for the double-data-rate burst SRAM model.
package ddrb_pkg;

    // Decoded command seen at a rising edge of K.
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } ddrb_cmd_e;

    // Decode the select and direction pins into a command.
    function automatic ddrb_cmd_e ddrb_decode(input logic sel_n, input logic dir_rd);
        if (sel_n)
            return CMD_IDLE;
        return dir_rd ? CMD_READ : CMD_WRITE;
    endfunction

endpackage

// File: rtl/ddrb_cmd_pipe.sv
`timescale 1ns/1ps
// Command pipeline: samples the control pins on each K rise.
// A read address is delayed two stages to reach the output stage.
// A write address is delayed one stage to meet its first data beat.
// Assumes the caller obeys the read-to-write turnaround.
module ddrb_cmd_pipe
    import ddrb_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_n,
    input  logic              rw,
    input  logic [ADDR_W-1:0] addr,
    output logic              rd2_v,
    output logic [ADDR_W-1:0] rd2_a,
    output logic              wr1_v,
    output logic [ADDR_W-1:0] wr1_a
);

    ddrb_cmd_e          cmd;
    logic               rd1_v_q;
    logic [ADDR_W-1:0]  rd1_a_q;

    // Decode the current command pins.
    always_comb cmd = ddrb_decode(ld_n, rw);

    // Shift read and write commands down their pipelines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd1_v_q <= 1'b0;
            rd2_v   <= 1'b0;
            wr1_v   <= 1'b0;
            rd1_a_q <= '0;
            rd2_a   <= '0;
            wr1_a   <= '0;
        end else begin
            rd1_v_q <= (cmd == CMD_READ);
            rd2_v   <= rd1_v_q;
            wr1_v   <= (cmd == CMD_WRITE);
            if (cmd == CMD_READ)
                rd1_a_q <= addr;
            rd2_a   <= rd1_a_q;
            if (cmd == CMD_WRITE)
                wr1_a <= addr;
        end
    end

endmodule

// File: rtl/ddrb_wr_path.sv
`timescale 1ns/1ps
// Write data path: collects the two beats of a write and posts it.
// Beat 0 is taken on the K rise after the command, and beat 1 on the next fall.
// The completed write moves into the holding register at the following K rise.
// The write it displaces is committed to the array in that same edge.
// Assumes write commands come no faster than one per K rise.
module ddrb_wr_path #(
    parameter int ADDR_W     = 6,
    parameter int BYTE_W     = 9,
    parameter int BEAT_BYTES = 2,
    localparam int BEAT_W     = BYTE_W * BEAT_BYTES,
    localparam int WORD_W     = 2 * BEAT_W,
    localparam int WORD_BYTES = 2 * BEAT_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr1_v,
    input  logic [ADDR_W-1:0]     wr1_a,
    input  logic [BEAT_W-1:0]     d_in,
    input  logic [BEAT_BYTES-1:0] bw_n,
    output logic                  coll_full,
    output logic                  commit_en,
    output logic                  post_v,
    output logic [ADDR_W-1:0]     post_a,
    output logic [WORD_W-1:0]     post_d,
    output logic [WORD_BYTES-1:0] post_m
);

    logic                  c_pend_q;
    logic [ADDR_W-1:0]     c_a_q;
    logic [BEAT_W-1:0]     c_lo_q;
    logic [BEAT_W-1:0]     c_hi_q;
    logic [BEAT_BYTES-1:0] c_mlo_q;
    logic [BEAT_BYTES-1:0] c_mhi_q;

    // Capture the first beat and its strobes on the K rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_pend_q <= 1'b0;
            c_a_q    <= '0;
            c_lo_q   <= '0;
            c_mlo_q  <= '0;
        end else begin
            c_pend_q <= wr1_v;
            if (wr1_v) begin
                c_a_q   <= wr1_a;
                c_lo_q  <= d_in;
                c_mlo_q <= ~bw_n;
            end
        end
    end

    // Capture the second beat and its strobes on the K# rise.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            c_hi_q  <= '0;
            c_mhi_q <= '0;
        end else if (c_pend_q) begin
            c_hi_q  <= d_in;
            c_mhi_q <= ~bw_n;
        end
    end

    // Move a completed write into the holding register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            post_v <= 1'b0;
            post_a <= '0;
            post_d <= '0;
            post_m <= '0;
        end else if (c_pend_q) begin
            post_v <= 1'b1;
            post_a <= c_a_q;
            post_d <= {c_hi_q, c_lo_q};
            post_m <= {c_mhi_q, c_mlo_q};
        end
    end

    // The held write goes to the array when a newer one replaces it.
    always_comb begin
        coll_full = c_pend_q;
        commit_en = c_pend_q && post_v;
    end

endmodule

// File: rtl/ddrb_array.sv
`timescale 1ns/1ps
// Storage array with byte-masked writes and an asynchronous read port.
// Contents are not cleared by reset.
// A read in the same edge as a write returns the old word.
module ddrb_array #(
    parameter int ADDR_W     = 6,
    parameter int BYTE_W     = 9,
    parameter int WORD_BYTES = 4,
    localparam int WORD_W = BYTE_W * WORD_BYTES,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_a,
    input  logic [WORD_W-1:0]     wr_d,
    input  logic [WORD_BYTES-1:0] wr_m,
    input  logic [ADDR_W-1:0]     rd_a,
    output logic [WORD_W-1:0]     rd_d
);

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] wr_word;

    // Merge strobed bytes over the stored word.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_mrg
        assign wr_word[b*BYTE_W +: BYTE_W] =
            wr_m[b] ? wr_d[b*BYTE_W +: BYTE_W] : mem[wr_a][b*BYTE_W +: BYTE_W];
    end

    // Commit the merged word.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_a] <= wr_word;
    end

    // Present the addressed word for the read path.
    always_comb rd_d = mem[rd_a];

endmodule

// File: rtl/ddrb_rd_out.sv
`timescale 1ns/1ps
// Read output stage: overlays held write bytes on the array word.
// It registers the word at a K rise and drives the low half until the K# rise.
// It then drives the high half until the next K rise.
// The phase is found by comparing a toggle flop on each edge.
module ddrb_rd_out #(
    parameter int ADDR_W     = 6,
    parameter int BYTE_W     = 9,
    parameter int BEAT_BYTES = 2,
    localparam int BEAT_W     = BYTE_W * BEAT_BYTES,
    localparam int WORD_W     = 2 * BEAT_W,
    localparam int WORD_BYTES = 2 * BEAT_BYTES
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd2_v,
    input  logic [ADDR_W-1:0]     rd2_a,
    input  logic [WORD_W-1:0]     arr_d,
    input  logic                  post_v,
    input  logic [ADDR_W-1:0]     post_a,
    input  logic [WORD_W-1:0]     post_d,
    input  logic [WORD_BYTES-1:0] post_m,
    output logic [BEAT_W-1:0]     q_out,
    output logic                  q_oe,
    output logic                  q_first
);

    logic              hit;
    logic [WORD_W-1:0] merged;
    logic [WORD_W-1:0] word_q;
    logic              oe_q;
    logic              pos_tag_q;
    logic              neg_tag_q;
    logic              hi_phase;

    // Detect a read of the held write's address.
    always_comb hit = post_v && (post_a == rd2_a);

    // Pick each byte from the held write or the array.
    for (genvar b = 0; b < WORD_BYTES; b++) begin : g_byp
        assign merged[b*BYTE_W +: BYTE_W] =
            (hit && post_m[b]) ? post_d[b*BYTE_W +: BYTE_W] : arr_d[b*BYTE_W +: BYTE_W];
    end

    // Load the outgoing word and the enable on the K rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q    <= '0;
            oe_q      <= 1'b0;
            pos_tag_q <= 1'b0;
        end else begin
            if (rd2_v)
                word_q <= merged;
            oe_q      <= rd2_v;
            pos_tag_q <= ~pos_tag_q;
        end
    end

    // Mark the K# rise so the second beat is selected.
    always_ff @(negedge clk) begin
        if (!rst_n)
            neg_tag_q <= 1'b0;
        else
            neg_tag_q <= pos_tag_q;
    end

    // Drive the beat that belongs to the current half cycle.
    always_comb begin
        hi_phase = (pos_tag_q == neg_tag_q);
        q_oe     = oe_q;
        q_first  = oe_q && !hi_phase;
        if (!oe_q)
            q_out = '0;
        else if (hi_phase)
            q_out = word_q[WORD_W-1:BEAT_W];
        else
            q_out = word_q[BEAT_W-1:0];
    end

endmodule

// File: rtl/ddr_burst_sram.sv
`timescale 1ns/1ps
// Top of the double-data-rate burst-of-two SRAM model.
// The rising edge of k_clk stands for K and the falling edge stands for K#.
// Assumes at least two idle K rises between a read command and a write command.
module ddr_burst_sram #(
    parameter int ADDR_W     = 6,
    parameter int BYTE_W     = 9,
    parameter int BEAT_BYTES = 2,
    localparam int BEAT_W     = BYTE_W * BEAT_BYTES,
    localparam int WORD_W     = 2 * BEAT_W,
    localparam int WORD_BYTES = 2 * BEAT_BYTES
) (
    input  logic                  k_clk,
    input  logic                  rst_n,
    input  logic                  ld_n,
    input  logic                  rw,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [BEAT_W-1:0]     d_in,
    input  logic [BEAT_BYTES-1:0] bw_n,
    output logic [BEAT_W-1:0]     q_out,
    output logic                  q_oe,
    output logic                  q_first
);

    logic                  rd2_v;
    logic [ADDR_W-1:0]     rd2_a;
    logic                  wr1_v;
    logic [ADDR_W-1:0]     wr1_a;
    logic                  coll_full;
    logic                  commit_en;
    logic                  post_v;
    logic [ADDR_W-1:0]     post_a;
    logic [WORD_W-1:0]     post_d;
    logic [WORD_BYTES-1:0] post_m;
    logic [WORD_W-1:0]     arr_d;

    ddrb_cmd_pipe #(.ADDR_W(ADDR_W)) u_cmd (
        .clk   (k_clk),
        .rst_n (rst_n),
        .ld_n  (ld_n),
        .rw    (rw),
        .addr  (addr),
        .rd2_v (rd2_v),
        .rd2_a (rd2_a),
        .wr1_v (wr1_v),
        .wr1_a (wr1_a)
    );

    ddrb_wr_path #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BEAT_BYTES(BEAT_BYTES)) u_wr (
        .clk       (k_clk),
        .rst_n     (rst_n),
        .wr1_v     (wr1_v),
        .wr1_a     (wr1_a),
        .d_in      (d_in),
        .bw_n      (bw_n),
        .coll_full (coll_full),
        .commit_en (commit_en),
        .post_v    (post_v),
        .post_a    (post_a),
        .post_d    (post_d),
        .post_m    (post_m)
    );

    ddrb_array #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES)) u_arr (
        .clk   (k_clk),
        .wr_en (commit_en),
        .wr_a  (post_a),
        .wr_d  (post_d),
        .wr_m  (post_m),
        .rd_a  (rd2_a),
        .rd_d  (arr_d)
    );

    ddrb_rd_out #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .BEAT_BYTES(BEAT_BYTES)) u_out (
        .clk     (k_clk),
        .rst_n   (rst_n),
        .rd2_v   (rd2_v),
        .rd2_a   (rd2_a),
        .arr_d   (arr_d),
        .post_v  (post_v),
        .post_a  (post_a),
        .post_d  (post_d),
        .post_m  (post_m),
        .q_out   (q_out),
        .q_oe    (q_oe),
        .q_first (q_first)
    );

endmodule

// File: rtl/ddrb_checker.sv
`timescale 1ns/1ps
// Protocol and timing checks for ddr_burst_sram, attached by bind.
module ddrb_checker #(
    parameter int BEAT_W = 18
) (
    input logic              k_clk,
    input logic              rst_n,
    input logic              ld_n,
    input logic              rw,
    input logic [BEAT_W-1:0] q_out,
    input logic              q_oe,
    input logic              q_first,
    input logic              coll_full,
    input logic              post_v
);

    logic rd_cmd;
    logic wr_cmd;
    assign rd_cmd = !ld_n && rw;
    assign wr_cmd = !ld_n && !rw;

    // R8: a read turns the bus on two K rises later
    a_r8_oe_after_read: assert property (@(posedge k_clk) disable iff (!rst_n)
        rd_cmd |-> ##3 q_oe);

    // R8: the bus is only on for a read issued two rises earlier
    a_r8_oe_needs_read: assert property (@(posedge k_clk) disable iff (!rst_n)
        q_oe |-> $past(rd_cmd, 3));

    // R8: disabled bus carries zeros
    a_r8_quiet_bus: assert property (@(posedge k_clk) disable iff (!rst_n)
        !q_oe |-> (q_out == '0));

    // R9: first-beat marker covers the whole first half of a burst
    a_r9_first_with_oe: assert property (@(negedge k_clk) disable iff (!rst_n)
        q_oe |-> q_first);

    // R9: first-beat marker never shows without the enable
    a_r9_first_gated: assert property (@(negedge k_clk) disable iff (!rst_n)
        q_first |-> q_oe);

    // R9: first-beat marker is gone in the second half
    a_r9_second_half: assert property (@(posedge k_clk) disable iff (!rst_n)
        !q_first);

    // R2: two idle rises between a read command and a write command
    a_r2_turnaround: assert property (@(posedge k_clk) disable iff (!rst_n)
        wr_cmd |-> (!$past(rd_cmd, 1) && !$past(rd_cmd, 2)));

    // R6: once a write is held, the holding register is never emptied
    a_r6_held_sticky: assert property (@(posedge k_clk) disable iff (!rst_n)
        post_v |=> post_v);

    // R6: a write being collected always ends up held
    a_r6_collect_posts: assert property (@(posedge k_clk) disable iff (!rst_n)
        coll_full |=> post_v);

endmodule

bind ddr_burst_sram ddrb_checker #(.BEAT_W(BEAT_W)) u_chk (
    .k_clk     (k_clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .rw        (rw),
    .q_out     (q_out),
    .q_oe      (q_oe),
    .q_first   (q_first),
    .coll_full (coll_full),
    .post_v    (post_v)
);

// File: tb/sim_ddr_burst_sram.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases plus seeded random traffic.
module sim_ddr_burst_sram;

    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic          k_clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_n  = 1'b1;
    logic          rw    = 1'b1;
    logic [AW-1:0] addr  = '0;
    logic [17:0]   d_in  = '0;
    logic [1:0]    bw_n  = 2'b11;
    logic [17:0]   q_out;
    logic          q_oe;
    logic          q_first;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [35:0] model [DEPTH];
    bit          r1_v = 0, r2_v = 0;
    logic [35:0] r1_d = '0, r2_d = '0;
    string       r1_t = "R3", r2_t = "R3";
    bit          pw_v = 0;
    logic [35:0] pw_d = '0;
    logic [3:0]  pw_m = '0;
    int          since_rd = 10;

    ddr_burst_sram #(.ADDR_W(AW)) u0 (
        .k_clk   (k_clk),
        .rst_n   (rst_n),
        .ld_n    (ld_n),
        .rw      (rw),
        .addr    (addr),
        .d_in    (d_in),
        .bw_n    (bw_n),
        .q_out   (q_out),
        .q_oe    (q_oe),
        .q_first (q_first)
    );

    always #2.5 k_clk = ~k_clk;

    task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    // Apply a write to the reference memory, byte by byte.
    function automatic logic [35:0] merge_word(input logic [35:0] old, input logic [35:0] nw,
                                               input logic [3:0] m);
        logic [35:0] r = old;
        for (int b = 0; b < 4; b++)
            if (m[b]) r[b*9 +: 9] = nw[b*9 +: 9];
        return r;
    endfunction

    // One K cycle. Entered 1.25 ns before a K rise. kind: 0 idle, 1 read, 2 write.
    task automatic cyc(input int kind, input logic [AW-1:0] a, input logic [35:0] wd,
                       input logic [3:0] wm, input string tag);
        bit          cur_v = 0;
        logic [35:0] cur_d = '0;
        ld_n = (kind == 0);
        rw   = (kind != 2);
        addr = a;
        if (kind == 0) begin
            rw   = 1'($urandom);
            addr = AW'($urandom);
        end
        if (pw_v) begin
            d_in = pw_d[17:0];
            bw_n = ~pw_m[1:0];
        end else begin
            d_in = 18'($urandom);
            bw_n = 2'($urandom);
        end
        if (kind == 1) begin
            cur_v    = 1;
            cur_d    = model[a];
            since_rd = 0;
        end else begin
            since_rd++;
        end
        if (kind == 2)
            model[a] = merge_word(model[a], wd, wm);
        @(posedge k_clk); #1.25;
        // first-beat window
        check("R8 oe", {35'b0, q_oe}, {35'b0, r2_v});
        check("R9 first", {35'b0, q_first}, {35'b0, r2_v});
        check(r2_v ? r2_t : "R8 idle bus", {18'b0, q_out}, r2_v ? {18'b0, r2_d[17:0]} : 36'b0);
        if (pw_v) begin
            d_in = pw_d[35:18];
            bw_n = ~pw_m[3:2];
        end else begin
            d_in = 18'($urandom);
            bw_n = 2'($urandom);
        end
        @(negedge k_clk); #1.25;
        // second-beat window
        check("R8 oe", {35'b0, q_oe}, {35'b0, r2_v});
        check("R9 first", {35'b0, q_first}, 36'b0);
        check(r2_v ? r2_t : "R8 idle bus", {18'b0, q_out}, r2_v ? {18'b0, r2_d[35:18]} : 36'b0);
        r2_v = r1_v; r2_d = r1_d; r2_t = r1_t;
        r1_v = cur_v; r1_d = cur_d; r1_t = tag;
        pw_v = (kind == 2); pw_d = wd; pw_m = wm;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, '0, '0, '0, "R10");
    endtask

    initial begin
        logic [35:0] w;
        void'($urandom(32'd20240611));
        // R11: outputs quiet under reset
        repeat (3) @(posedge k_clk);
        #1.25;
        check("R11 oe", {35'b0, q_oe}, 36'b0);
        check("R11 first", {35'b0, q_first}, 36'b0);
        check("R11 q", {18'b0, q_out}, 36'b0);
        @(negedge k_clk); #1.25;
        rst_n = 1'b1;
        // R2 R4: fill every address with full strobes
        for (int i = 0; i < DEPTH; i++)
            cyc(2, AW'(i), {$urandom, 4'($urandom)}, 4'hF, "R3");
        idle(2);
        // R12 R1: back-to-back reads
        for (int i = 0; i < 8; i++) cyc(1, AW'(i), '0, '0, "R12");
        idle(2);
        // R7: read one cycle after a full write to the same address
        cyc(2, 6'd5, 36'h123456789, 4'hF, "R7");
        cyc(1, 6'd5, '0, '0, "R7");
        idle(2);
        // R5 R7: partial strobes merge held bytes with array bytes
        cyc(2, 6'd9, 36'hABCDEF012, 4'b0101, "R5");
        cyc(1, 6'd9, '0, '0, "R5");
        cyc(1, 6'd9, '0, '0, "R7");
        idle(2);
        // R6: held write stays readable, then reaches the array
        cyc(2, 6'd12, 36'h0F0F0F0F0, 4'hF, "R6");
        cyc(1, 6'd12, '0, '0, "R6");
        idle(2);
        cyc(1, 6'd12, '0, '0, "R6");
        idle(2);
        cyc(2, 6'd13, 36'h5A5A5A5A5, 4'b1010, "R6");
        cyc(1, 6'd12, '0, '0, "R6");
        cyc(1, 6'd13, '0, '0, "R6");
        idle(2);
        // R10: deselected cycles with random pins, then read back
        idle(12);
        for (int i = 0; i < 4; i++) cyc(1, AW'(i), '0, '0, "R10");
        idle(2);
        // R11: reset while a read is in flight
        cyc(1, 6'd3, '0, '0, "R11");
        rst_n = 1'b0;
        r1_v = 0; r2_v = 0; pw_v = 0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // Random traffic over a narrow range to provoke collisions
        for (int i = 0; i < 1500; i++) begin
            int r = int'($urandom % 10);
            w = {$urandom, 4'($urandom)};
            if (r < 4)
                cyc(1, AW'($urandom % 8), '0, '0, "R7");
            else if (r < 7 && since_rd >= 2)
                cyc(2, AW'($urandom % 8), w, 4'($urandom), "R6");
            else
                cyc(0, '0, '0, '0, "R10");
        end
        idle(3);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge k_clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule